// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns bytes written over a small register bus into asynchronous serial frames on a single output line. Software first sets the bit rate by opening the divisor bank and writing a 16-bit divisor as two bytes. It then picks the frame shape through the line-format register: data width, parity style and stop-bit count. After that it writes characters into a one-byte holding register. An internal tick generator runs sixteen times per bit. The block moves the held byte into a shift register and sends a low start bit, then the data bits least significant first, then an optional parity bit, then one or two high stop bits.

Two status flags can be read back. One says that the holding register can accept another byte. The other says that the whole transmitter has gone quiet. Software can also hold the line low (a break) for as long as it likes. A divisor of zero freezes the bit timing in place.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset the line output is high, the status register (offset 5) reads 0x60, the line-format register (offset 3) reads 0x00 and both divisor bytes read 0x00.
- R2: While line-format bit 7 is 1, offsets 0 and 1 write and read the divisor low and high bytes. While it is 0, a write to offset 0 goes to the holding register, a write to offset 1 has no effect, and reads of offsets 0 and 1 return 0x00.
- R3: Each serial bit lasts 16 x divisor clock cycles. A frame begins with one low start bit, and data bits leave least significant bit first.
- R4: The number of data bits sent equals line-format bits [1:0] plus 5. Holding-register bits above that width are not sent.
- R5: Line-format bit 2 = 0 gives one high stop bit and = 1 gives two.
- R6: With line-format bit 3 = 1 a parity bit follows the data. When bit 4 = 1 it makes the count of ones in the data and parity even; when bit 4 = 0 it makes that count odd.
- R7: With bits 3 and 5 both set, the parity bit is a constant: 0 when bit 4 = 1, 1 when bit 4 = 0.
- R8: While line-format bit 6 is 1 the line output is low, from the second clock edge after the write. Clearing the bit restores the line one edge later. The status flags are unaffected.
- R9: Status bit 5 (holding empty) reads 0 right after a data write and returns to 1 one clock later, when an idle transmitter takes the byte into its shift register.
- R10: Status bit 6 (transmitter empty) is 1 only when the holding register is empty and the final stop bit has finished. A byte that waits in the holding register starts right after the previous stop bit, with no idle gap.
- R11: With a divisor of 0 no bit timing advances. The line stays at its current level until a non-zero divisor is written, and then the frame completes.
- R12: The data width, parity and stop settings are captured when a byte enters the shift register. Changing the line format during a frame affects only later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 3 | Register offset |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr (combinational) |
| txOut | output | 1 | Serial output, high when idle |

## Verification
The assertions assume that each register write is a single-cycle strobe. They also assume the divisor is not shrunk to 1 in the cycle right after a tick. The bench changes the divisor only while the transmitter is idle, apart from the deliberate freeze-and-resume case. The receive model samples the line at bit centres measured from the falling start edge, using a divisor of 2 or 3. The tick generator is not resynchronised at frame start, so the start bit can be up to one divisor period short. That stays well inside the half-bit sampling margin. The format sweep covers all 64 combinations of the low six line-format bits, each with a byte and its complement.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam logic [2:0] ADDR_DATA  = 3'd0;
  localparam logic [2:0] ADDR_DIVHI = 3'd1;
  localparam logic [2:0] ADDR_LINE  = 3'd3;
  localparam logic [2:0] ADDR_STAT  = 3'd5;

  localparam int unsigned STAT_HOLD_EMPTY = 5;
  localparam int unsigned STAT_ALL_EMPTY  = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } txState_t;

  typedef struct packed {
    logic load;
    logic nextData;
    logic nextParity;
    logic nextStop;
    logic goIdle;
  } txStrobes_t;

  typedef struct packed {
    logic [1:0] wordSel;
    logic       twoStop;
    logic       parEn;
  } frameCfg_t;

endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);

  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt;

  always_comb tick = (divisor != '0) && (cnt >= divisor - ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         cnt <= '0;
    else if (divisor == '0 || tick)    cnt <= '0;
    else                               cnt <= cnt + ONE;
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    (tick && divisor > ONE) |=> (!tick || divisor != $past(divisor))); // R3

endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
#(
  parameter int unsigned TICKS_PER_BIT = 16,
  parameter int unsigned DATA_W        = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       holdFull,
  input  frameCfg_t  cfg,
  output txStrobes_t strobes,
  output logic       busy
);

  localparam int unsigned PH_W  = $clog2(TICKS_PER_BIT);
  localparam int unsigned IDX_W = $clog2(DATA_W);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(TICKS_PER_BIT - 1);

  txState_t         state, stateNext;
  logic [PH_W-1:0]  phase;
  logic [IDX_W-1:0] bitIdx, bitIdxNext;
  logic             stopIdx, stopIdxNext;
  logic             lastTick;
  logic [IDX_W:0]   wordLen;

  always_comb begin
    lastTick = tick && (phase == PH_LAST);
    wordLen  = (IDX_W+1)'(cfg.wordSel) + (IDX_W+1)'(5);
    busy     = (state != ST_IDLE);
  end

  always_comb begin
    strobes     = '0;
    stateNext   = state;
    bitIdxNext  = bitIdx;
    stopIdxNext = stopIdx;
    case (state)
      ST_IDLE: begin
        if (holdFull) begin
          strobes.load = 1'b1;
          stateNext    = ST_START;
        end
      end
      ST_START: begin
        if (lastTick) begin
          strobes.nextData = 1'b1;
          stateNext        = ST_DATA;
          bitIdxNext       = '0;
        end
      end
      ST_DATA: begin
        if (lastTick) begin
          if ({1'b0, bitIdx} == wordLen - (IDX_W+1)'(1)) begin
            stopIdxNext = 1'b0;
            if (cfg.parEn) begin
              strobes.nextParity = 1'b1;
              stateNext          = ST_PARITY;
            end else begin
              strobes.nextStop = 1'b1;
              stateNext        = ST_STOP;
            end
          end else begin
            strobes.nextData = 1'b1;
            bitIdxNext       = bitIdx + IDX_W'(1);
          end
        end
      end
      ST_PARITY: begin
        if (lastTick) begin
          strobes.nextStop = 1'b1;
          stateNext        = ST_STOP;
          stopIdxNext      = 1'b0;
        end
      end
      ST_STOP: begin
        if (lastTick) begin
          if (cfg.twoStop && !stopIdx) begin
            stopIdxNext = 1'b1;
          end else if (holdFull) begin
            strobes.load = 1'b1;
            stateNext    = ST_START;
          end else begin
            strobes.goIdle = 1'b1;
            stateNext      = ST_IDLE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      phase   <= '0;
      bitIdx  <= '0;
      stopIdx <= 1'b0;
    end else begin
      state   <= stateNext;
      bitIdx  <= bitIdxNext;
      stopIdx <= stopIdxNext;
      if (state == ST_IDLE)  phase <= '0;
      else if (tick)         phase <= lastTick ? '0 : phase + PH_W'(1);
    end
  end

  AST_FREEZE_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && !tick) |=> ($stable(state) && $stable(phase))); // R11

  AST_BIT_IN_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA) |-> ({1'b0, bitIdx} < wordLen)); // R4

endmodule

// File: rtl/uart_tx_datapath.sv
module uart_tx_datapath
  import uart_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       busAddr,
  input  logic             busWrEn,
  input  logic [7:0]       busWrData,
  output logic [7:0]       busRdData,
  input  txStrobes_t       strobes,
  input  logic             ctrlBusy,
  output frameCfg_t        cfgLatched,
  output logic             holdFull,
  output logic [DIV_W-1:0] divisor,
  output logic             breakOn,
  output logic             txIdle,
  output logic             txOut
);

  localparam int unsigned HI_W = DIV_W - 8;

  logic [7:0]        lineFmt;
  logic [DIV_W-1:0]  divReg;
  logic [DATA_W-1:0] holdReg, shiftReg, wordMask;
  logic              parReg, lineReg, outReg;
  logic              bankDiv, wrHold, wrDivLo, wrDivHi, wrFmt;
  logic              onesOdd, parNext;

  always_comb begin
    bankDiv = lineFmt[7];
    wrHold  = busWrEn && busAddr == ADDR_DATA  && !bankDiv;
    wrDivLo = busWrEn && busAddr == ADDR_DATA  &&  bankDiv;
    wrDivHi = busWrEn && busAddr == ADDR_DIVHI &&  bankDiv;
    wrFmt   = busWrEn && busAddr == ADDR_LINE;
    for (int i = 0; i < DATA_W; i++)
      wordMask[i] = (i < int'(lineFmt[1:0]) + 5);
    onesOdd = ^(holdReg & wordMask);
    if (lineFmt[5]) parNext = ~lineFmt[4];
    else            parNext = lineFmt[4] ? onesOdd : ~onesOdd;
    breakOn = lineFmt[6];
    divisor = divReg;
    txIdle  = !holdFull && !ctrlBusy;
    txOut   = outReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineFmt    <= '0;
      divReg     <= '0;
      holdReg    <= '0;
      holdFull   <= 1'b0;
      shiftReg   <= '0;
      cfgLatched <= '0;
      parReg     <= 1'b0;
      lineReg    <= 1'b1;
      outReg     <= 1'b1;
    end else begin
      if (wrFmt)   lineFmt      <= busWrData;
      if (wrDivLo) divReg[7:0]  <= busWrData;
      if (wrDivHi) divReg[DIV_W-1:8] <= busWrData[HI_W-1:0];
      if (wrHold)  holdReg      <= busWrData[DATA_W-1:0];
      holdFull <= wrHold ? 1'b1 : (strobes.load ? 1'b0 : holdFull);
      if (strobes.load) begin
        shiftReg   <= holdReg & wordMask;
        cfgLatched <= '{wordSel: lineFmt[1:0], twoStop: lineFmt[2], parEn: lineFmt[3]};
        parReg     <= parNext;
        lineReg    <= 1'b0;
      end else if (strobes.nextData) begin
        lineReg  <= shiftReg[0];
        shiftReg <= shiftReg >> 1;
      end else if (strobes.nextParity) begin
        lineReg <= parReg;
      end else if (strobes.nextStop || strobes.goIdle) begin
        lineReg <= 1'b1;
      end
      outReg <= lineReg && !lineFmt[6];
    end
  end

  always_comb begin
    busRdData = '0;
    case (busAddr)
      ADDR_DATA:  if (bankDiv) busRdData = divReg[7:0];
      ADDR_DIVHI: if (bankDiv) busRdData = 8'(divReg[DIV_W-1:8]);
      ADDR_LINE:  busRdData = lineFmt;
      ADDR_STAT: begin
        busRdData[STAT_HOLD_EMPTY] = !holdFull;
        busRdData[STAT_ALL_EMPTY]  = txIdle;
      end
      default: busRdData = '0;
    endcase
  end

  AST_LOAD_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |-> holdFull); // R9

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.load, strobes.nextData, strobes.nextParity,
              strobes.nextStop, strobes.goIdle})); // R3

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned DIV_W         = 16,
  parameter int unsigned TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] busAddr,
  input  logic       busWrEn,
  input  logic [7:0] busWrData,
  output logic [7:0] busRdData,
  output logic       txOut
);

  txStrobes_t       strobes;
  frameCfg_t        cfgLatched;
  logic             holdFull, busy, tick, breakOn, txIdle;
  logic [DIV_W-1:0] divisor;

  uart_tx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk     (clk),
    .rstN    (rstN),
    .divisor (divisor),
    .tick    (tick)
  );

  uart_tx_ctrl #(.TICKS_PER_BIT(TICKS_PER_BIT), .DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick),
    .holdFull (holdFull),
    .cfg      (cfgLatched),
    .strobes  (strobes),
    .busy     (busy)
  );

  uart_tx_datapath #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .busAddr    (busAddr),
    .busWrEn    (busWrEn),
    .busWrData  (busWrData),
    .busRdData  (busRdData),
    .strobes    (strobes),
    .ctrlBusy   (busy),
    .cfgLatched (cfgLatched),
    .holdFull   (holdFull),
    .divisor    (divisor),
    .breakOn    (breakOn),
    .txIdle     (txIdle),
    .txOut      (txOut)
  );

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (txIdle && !breakOn && !$past(breakOn)) |-> txOut); // R10

endmodule

// File: tb/uart_frame_tx_tb.sv
module uart_frame_tx_tb;

  logic       clk = 1'b0;
  logic       rstN;
  logic [2:0] busAddr;
  logic       busWrEn;
  logic [7:0] busWrData;
  logic [7:0] busRdData;
  logic       txOut;

  int nChecks = 0;
  int nFail   = 0;
  int cycles  = 0;
  localparam int WATCHDOG = 190000;

  always #2.5 clk = ~clk;

  uart_frame_tx u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .txOut(txOut)
  );

  task automatic printSummary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WATCHDOG) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finished");
      printSummary();
      $finish;
    end
  end

  task automatic checkVal(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [7:0] v);
    @(negedge clk);
    busAddr = a; busWrData = v; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [7:0] v);
    busAddr = a;
    #1;
    v = busRdData;
  endtask

  task automatic setDivisor(input logic [15:0] d, input logic [7:0] fmt);
    busWrite(3'd3, 8'h80 | fmt);
    busWrite(3'd0, d[7:0]);
    busWrite(3'd1, d[15:8]);
    busWrite(3'd3, fmt);
  endtask

  task automatic waitIdle();
    logic [7:0] st;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      busRead(3'd5, st);
      if (st[6]) break;
    end
  endtask

  // start bit in position 0, then data LSB first, parity, stop bits
  function automatic int buildFrame(input logic [7:0] fmt, input logic [7:0] d,
                                    output logic [12:0] bits);
    int n, wl, ones;
    logic par;
    bits = '0;
    n = 1;
    wl = int'(fmt[1:0]) + 5;
    ones = 0;
    for (int i = 0; i < wl; i++) begin
      bits[n] = d[i];
      ones += int'(d[i]);
      n++;
    end
    if (fmt[3]) begin
      if (fmt[5])      par = ~fmt[4];
      else if (fmt[4]) par = ones[0];
      else             par = ~ones[0];
      bits[n] = par;
      n++;
    end
    bits[n] = 1'b1; n++;
    if (fmt[2]) begin bits[n] = 1'b1; n++; end
    return n;
  endfunction

  task automatic rxFrame(input logic [7:0] fmt, input logic [7:0] d, input int div,
                         input bit doTemt, input string tag, output int gap);
    logic [12:0] expBits, gotBits;
    logic [7:0]  st;
    int n;
    n = buildFrame(fmt, d, expBits);
    gotBits = '0;
    gap = 0;
    @(negedge clk);
    while (txOut !== 1'b0 && gap < 20000) begin
      @(negedge clk);
      gap++;
    end
    repeat (8*div) @(negedge clk);
    gotBits[0] = txOut;
    for (int i = 1; i < n; i++) begin
      repeat (16*div) @(negedge clk);
      gotBits[i] = txOut;
    end
    checkVal(tag, 32'(gotBits), 32'(expBits));
    busRead(3'd5, st);
    checkVal("R10 all-empty low during stop bit", 32'(st[6]), 32'd0);
    if (doTemt) begin
      repeat (8*div + 4) @(negedge clk);
      busRead(3'd5, st);
      checkVal("R10 all-empty after final stop", 32'(st[6]), 32'd1);
    end
  endtask

  logic [7:0] rd;
  int gapA, gapB, per;
  logic [7:0] base, dat;

  initial begin
    rstN = 1'b0; busWrEn = 1'b0; busAddr = '0; busWrData = '0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    checkVal("R1 line idle high", 32'(txOut), 32'd1);
    busRead(3'd5, rd); checkVal("R1 status reset", 32'(rd), 32'h60);
    busRead(3'd3, rd); checkVal("R1 format reset", 32'(rd), 32'h00);
    busWrite(3'd3, 8'h80);
    busRead(3'd0, rd); checkVal("R1 divisor low reset", 32'(rd), 32'h00);
    busRead(3'd1, rd); checkVal("R1 divisor high reset", 32'(rd), 32'h00);

    // R2 banking
    busWrite(3'd0, 8'h02);
    busWrite(3'd1, 8'h5A);
    busRead(3'd0, rd); checkVal("R2 divisor low readback", 32'(rd), 32'h02);
    busRead(3'd1, rd); checkVal("R2 divisor high readback", 32'(rd), 32'h5A);
    busWrite(3'd1, 8'h00);
    busWrite(3'd3, 8'h03);
    busRead(3'd0, rd); checkVal("R2 offset0 unbanked read", 32'(rd), 32'h00);
    busRead(3'd1, rd); checkVal("R2 offset1 unbanked read", 32'(rd), 32'h00);
    busWrite(3'd1, 8'hFF);
    busRead(3'd5, rd); checkVal("R2 offset1 write starts nothing", 32'(rd), 32'h60);
    busWrite(3'd3, 8'h83);
    busRead(3'd1, rd); checkVal("R2 offset1 write ignored", 32'(rd), 32'h00);
    busWrite(3'd3, 8'h03);

    // R9 holding-empty timing with a full frame
    fork
      rxFrame(8'h03, 8'hA7, 2, 1'b1, "R3 R9 8N1 frame", gapA);
      begin
        busWrite(3'd0, 8'hA7);
        busRead(3'd5, rd); checkVal("R9 status right after write", 32'(rd), 32'h00);
        @(negedge clk);
        busRead(3'd5, rd); checkVal("R9 status after transfer", 32'(rd), 32'h20);
      end
    join

    // R3 bit period with divisor 3
    setDivisor(16'd3, 8'h03);
    busWrite(3'd0, 8'h55);
    while (txOut !== 1'b0) @(negedge clk);
    while (txOut !== 1'b1) @(negedge clk);
    per = 0;
    while (txOut !== 1'b0 && per < 1000) begin @(negedge clk); per++; end
    checkVal("R3 bit period 16x3", 32'(per), 32'd48);
    waitIdle();
    setDivisor(16'd2, 8'h03);

    // R4 R5 R6 R7 format sweep
    for (int f = 0; f < 64; f++) begin
      for (int k = 0; k < 2; k++) begin
        base = 8'(f * 37 + 11);
        dat  = k ? ~base : base;
        busWrite(3'd3, 8'(f));
        fork
          rxFrame(8'(f), dat, 2, 1'b1, "R4/R5/R6/R7 format sweep", gapA);
          busWrite(3'd0, dat);
        join
      end
    end

    // R10 back-to-back frames
    busWrite(3'd3, 8'h03);
    fork
      begin
        rxFrame(8'h03, 8'h3C, 2, 1'b0, "R10 first of pair", gapA);
        rxFrame(8'h03, 8'hE1, 2, 1'b1, "R10 second of pair", gapB);
        checkVal("R10 no idle gap", 32'(gapB <= 20), 32'd1);
      end
      begin
        busWrite(3'd0, 8'h3C);
        repeat (3) @(negedge clk);
        busWrite(3'd0, 8'hE1);
      end
    join

    // R12 format captured at load
    fork
      rxFrame(8'h03, 8'hC3, 2, 1'b1, "R12 format change mid-frame", gapA);
      begin
        busWrite(3'd0, 8'hC3);
        repeat (40) @(negedge clk);
        busWrite(3'd3, 8'h3C);
      end
    join
    busWrite(3'd3, 8'h03);

    // R8 break
    busWrite(3'd3, 8'h43);
    @(negedge clk);
    checkVal("R8 break drives low", 32'(txOut), 32'd0);
    repeat (200) @(negedge clk);
    checkVal("R8 break held low", 32'(txOut), 32'd0);
    busRead(3'd5, rd); checkVal("R8 status unaffected", 32'(rd), 32'h60);
    busWrite(3'd3, 8'h03);
    @(negedge clk);
    checkVal("R8 break released", 32'(txOut), 32'd1);

    // R11 divisor zero freezes timing
    setDivisor(16'd0, 8'h03);
    busWrite(3'd0, 8'h00);
    repeat (10) @(negedge clk);
    checkVal("R11 start bit driven", 32'(txOut), 32'd0);
    repeat (3000) @(negedge clk);
    checkVal("R11 line frozen", 32'(txOut), 32'd0);
    busRead(3'd5, rd); checkVal("R11 frame still pending", 32'(rd), 32'h20);
    setDivisor(16'd2, 8'h03);
    waitIdle();
    busRead(3'd5, rd); checkVal("R11 frame resumes and completes", 32'(rd), 32'h60);
    checkVal("R11 line idle after resume", 32'(txOut), 32'd1);

    printSummary();
    $finish;
  end

endmodule